// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave end of a two-wire serial bus (clock line and open-drain data line, I2C-style) in front of a 512-byte byte-addressed store and a small side space with two 8-bit registers. Both bus lines are brought into the system clock domain and watched for clock edges and for start and stop conditions. After a start, the slave takes in an address byte. The four upper bits of that byte pick the target space. The next-lowest bit gives the top bit of a 9-bit memory address for writes. The last bit picks the transfer direction.

A write sequence delivers a word address and then any number of data bytes, each of which lands at the running address counter. If the master ends the sequence with a stop right after the word address, only the counter is reloaded. A read returns bytes starting at the counter. The master may keep the read going with acknowledges, and the counter wraps from the top of the space back to zero. The slave acknowledges by pulling the data line low through `sda_oe_o`. The pad around it forms the open-drain bus.

Top module: `twi_mem_slave`

## Requirements
- R1: Both lines pass through two flip-flops before edge detection. A falling data line while the clock line is high is a start, and a rising data line while the clock line is high is a stop. A start in any state, including partway through a byte, begins reception of a new address byte and discards the partial byte. A stop returns the slave to standby.
- R2: The address byte is received MSB first. Bits 7:4 are the device type: 1010 is the memory array and 1011 is the register space. Bits 3:2 must be 00, bit 1 is address bit 8, and bit 0 is the direction (1 read, 0 write). The slave acknowledges a matching byte by driving the data line low for the ninth clock. On any other type, or on a nonzero fixed bit, it does not acknowledge and ignores the bus until the next start.
- R3: In a write sequence, the byte after the address byte is the low eight address bits. The counter is loaded with {address-byte bit 1, that byte}, and the byte is acknowledged.
- R4: Each further byte in a write sequence is stored at the counter and acknowledged, and the counter then advances by one.
- R5: A write sequence stopped right after the word-address byte loads the counter and changes no stored byte. The next current-address read returns the byte at the loaded address.
- R6: A word-address write followed by a repeated start and a read address byte returns the byte at the loaded address.
- R7: A read address byte uses the counter as it stands and ignores its bit 1. After each byte sent or stored the counter points one further, so a current-address read that follows a write or read at n returns the byte at n+1.
- R8: In a read, each master acknowledge makes the slave send the byte at the next address. The address after 1FFh is 000h.
- R9: A master non-acknowledge ends a read. The slave keeps the data line released and ignores the bus until a start. The counter keeps the value it reached.
- R10: In the 1011 space, address 1FFh is a control register and 0FFh is a fault register. Both are written and read like array bytes. Other addresses in that space read 00h and ignore writes, and writes to this space leave the array unchanged.
- R11: The slave changes its data-line drive only while the clock line is low. It sends data bits MSB first and releases the line for a 1.
- R12: Under reset the data line is released and the slave waits in standby. Both registers of the 1011 space read 00h after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
A wrong protocol state shows up as a missing or extra acknowledge within the ninth clock of the byte in flight. It can also show up as a data bit driven during the wrong clock, which the master sees at the very next clock-high sample. A corrupted address counter stays hidden until the next read. It then shows as the wrong byte from a current-address or sequential read, so the tests end each write path with a read that depends on where the counter should stand. A register that should be unreachable is probed by reading a known neighbour after the stimulus.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam logic [3:0] DEV_ARRAY = 4'b1010;
  localparam logic [3:0] DEV_REGS  = 4'b1011;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_WORD,
    ST_ACK_WORD,
    ST_WDATA,
    ST_ACK_DATA,
    ST_RDATA,
    ST_RACK
  } twi_state_e;

  typedef enum logic {
    SPACE_ARRAY = 1'b0,
    SPACE_REGS  = 1'b1
  } twi_space_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic [STAGES-1:0] scl_pipe_d, sda_pipe_d;
  logic              scl_last_q, sda_last_q;

  always_comb begin
    scl_pipe_d = {scl_pipe_q[STAGES-2:0], scl_i};
    sda_pipe_d = {sda_pipe_q[STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_last_q <= 1'b1;
      sda_last_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_last_q <= scl_pipe_q[STAGES-1];
      sda_last_q <= sda_pipe_q[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe_q[STAGES-1];
  assign sda_o      = sda_pipe_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_last_q;
  assign scl_fall_o = ~scl_o & scl_last_q;
  assign start_o    = scl_o & scl_last_q & sda_last_q & ~sda_o;
  assign stop_o     = scl_o & scl_last_q & ~sda_last_q & sda_o;

  // R1: a synchronized clock rise reflects the pin value STAGES cycles back
  assert_sync_depth_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_o) |-> $past(scl_i, STAGES));
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ctr_o
);
  logic [ADDR_W-1:0] ctr_q, ctr_d;

  always_comb begin
    ctr_d = ctr_q;
    if (load_i)     ctr_d = load_val_i;
    else if (inc_i) ctr_d = ctr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctr_q <= '0;
    else        ctr_q <= ctr_d;
  end

  assign ctr_o = ctr_q;

  // R8: stepping past the top address lands on zero
  assert_ctr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inc_i) && !$past(load_i) && ($past(ctr_q) == '1)) |-> (ctr_q == '0));
endmodule

// File: rtl/twi_mem_store.sv
module twi_mem_store
  import twi_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  twi_space_e        space_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int                DEPTH      = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = '1;
  localparam logic [ADDR_W-1:0] FAULT_ADDR = {1'b0, {(ADDR_W-1){1'b1}}};

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] ctrl_q, ctrl_d, fault_q, fault_d;
  logic              arr_we, reg_we;

  assign arr_we = wr_en_i && (space_i == SPACE_ARRAY);
  assign reg_we = wr_en_i && (space_i == SPACE_REGS);

  always_ff @(posedge clk) begin
    if (arr_we) mem_q[addr_i] <= wdata_i;
  end

  always_comb begin
    ctrl_d  = ctrl_q;
    fault_d = fault_q;
    if (reg_we && (addr_i == CTRL_ADDR))  ctrl_d  = wdata_i;
    if (reg_we && (addr_i == FAULT_ADDR)) fault_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      fault_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      fault_q <= fault_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (space_i == SPACE_ARRAY)   rdata_o = mem_q[addr_i];
    else if (addr_i == CTRL_ADDR)  rdata_o = ctrl_q;
    else if (addr_i == FAULT_ADDR) rdata_o = fault_q;
  end

  // R10: side registers only move on a write strobe from the protocol engine
  assert_regs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en_i) |-> ($stable(ctrl_q) && $stable(fault_q)));
endmodule

// File: rtl/twi_proto_fsm.sv
module twi_proto_fsm
  import twi_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl_i,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wdata_o,
  output twi_space_e        space_o,
  output logic              ctr_load_o,
  output logic [ADDR_W-1:0] ctr_load_val_o,
  output logic              ctr_inc_o,
  output logic              sda_oe_o
);
  localparam int               CNT_W    = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BITS_ALL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] BITS_TOP = CNT_W'(DATA_W - 1);

  twi_state_e        state_q, state_d;
  logic [CNT_W-1:0]  bits_q, bits_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              rw_q, rw_d;
  twi_space_e        space_q, space_d;
  logic              a8_q, a8_d;
  logic              mack_q, mack_d;
  logic              oe_q, oe_d;
  logic              addr_match;

  assign addr_match = (sh_q[7:5] == DEV_ARRAY[3:1]) && (sh_q[3:2] == 2'b00);

  always_comb begin
    state_d    = state_q;
    bits_d     = bits_q;
    sh_d       = sh_q;
    rw_d       = rw_q;
    space_d    = space_q;
    a8_d       = a8_q;
    mack_d     = mack_q;
    wr_en_o    = 1'b0;
    ctr_load_o = 1'b0;
    ctr_inc_o  = 1'b0;
    if (stop_i) begin
      state_d = ST_IDLE;
    end else if (start_i) begin
      state_d = ST_ADDR;
      bits_d  = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR, ST_WORD, ST_WDATA: begin
          if (scl_rise_i && (bits_q != BITS_ALL)) begin
            sh_d   = {sh_q[DATA_W-2:0], sda_lvl_i};
            bits_d = bits_q + 1'b1;
          end else if (scl_fall_i && (bits_q == BITS_ALL)) begin
            bits_d = '0;
            if (state_q == ST_ADDR) begin
              if (addr_match) begin
                state_d = ST_ACK_ADDR;
                rw_d    = sh_q[0];
                space_d = sh_q[4] ? SPACE_REGS : SPACE_ARRAY;
                if (!sh_q[0]) a8_d = sh_q[1];
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_WORD) begin
              state_d    = ST_ACK_WORD;
              ctr_load_o = 1'b1;
            end else begin
              state_d   = ST_ACK_DATA;
              wr_en_o   = 1'b1;
              ctr_inc_o = 1'b1;
            end
          end
        end
        ST_ACK_ADDR: begin
          if (scl_fall_i) begin
            if (rw_q) begin
              state_d   = ST_RDATA;
              sh_d      = rdata_i;
              bits_d    = '0;
              ctr_inc_o = 1'b1;
            end else begin
              state_d = ST_WORD;
            end
          end
        end
        ST_ACK_WORD, ST_ACK_DATA: begin
          if (scl_fall_i) state_d = ST_WDATA;
        end
        ST_RDATA: begin
          if (scl_fall_i) begin
            if (bits_q == BITS_TOP) begin
              state_d = ST_RACK;
              bits_d  = '0;
            end else begin
              sh_d   = {sh_q[DATA_W-2:0], 1'b0};
              bits_d = bits_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) mack_d = ~sda_lvl_i;
          if (scl_fall_i) begin
            if (mack_q) begin
              state_d   = ST_RDATA;
              sh_d      = rdata_i;
              ctr_inc_o = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
    oe_d = (state_d inside {ST_ACK_ADDR, ST_ACK_WORD, ST_ACK_DATA}) ||
           ((state_d == ST_RDATA) && !sh_d[DATA_W-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bits_q  <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      space_q <= SPACE_ARRAY;
      a8_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bits_q  <= bits_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      space_q <= space_d;
      a8_q    <= a8_d;
      mack_q  <= mack_d;
      oe_q    <= oe_d;
    end
  end

  assign wdata_o        = sh_q;
  assign space_o        = space_q;
  assign ctr_load_val_o = {a8_q, sh_q};
  assign sda_oe_o       = oe_q;

  // R11: drive on the data line only moves while the clock line is low
  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_lvl_i);

  // R2: the address acknowledge follows only a byte with a known type and 00
  assert_ack_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_ACK_ADDR) && ($past(state_q) == ST_ADDR)) |->
      (($past(sh_q[7:5]) == 3'b101) && ($past(sh_q[3:2]) == 2'b00)));

  // R9: standby is left only through a start
  assert_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && !start_i) |=> (state_q == ST_IDLE));

  // R4: the bit counter never runs past one full byte
  assert_bits_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q <= BITS_ALL);
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  logic              scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic              wr_en, ctr_load, ctr_inc;
  logic [DATA_W-1:0] wdata, rdata;
  logic [ADDR_W-1:0] ctr_val, ctr_load_val;
  twi_space_e        space;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  twi_proto_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_lvl_i      (scl_s),
    .sda_lvl_i      (sda_s),
    .scl_rise_i     (scl_rise),
    .scl_fall_i     (scl_fall),
    .start_i        (bus_start),
    .stop_i         (bus_stop),
    .rdata_i        (rdata),
    .wr_en_o        (wr_en),
    .wdata_o        (wdata),
    .space_o        (space),
    .ctr_load_o     (ctr_load),
    .ctr_load_val_o (ctr_load_val),
    .ctr_inc_o      (ctr_inc),
    .sda_oe_o       (sda_oe_o)
  );

  twi_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ctr_load),
    .load_val_i (ctr_load_val),
    .inc_i      (ctr_inc),
    .ctr_o      (ctr_val)
  );

  twi_mem_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en),
    .space_i (space),
    .addr_i  (ctr_val),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );
endmodule

// File: tb/twi_mem_slave_tb_top.sv
module twi_mem_slave_tb_top;
  localparam int         Q     = 6;
  localparam logic [3:0] T_ARR = 4'b1010;
  localparam logic [3:0] T_REG = 4'b1011;
  localparam int         NVEC  = 9;
  localparam logic [16:0] VEC [NVEC] = '{
    {9'h000, 8'hA5}, {9'h001, 8'h3C}, {9'h002, 8'hD4},
    {9'h0FF, 8'h77}, {9'h100, 8'hC3}, {9'h155, 8'h5A},
    {9'h1FE, 8'hE1}, {9'h1FF, 8'h1E}, {9'h080, 8'h99}
  };

  logic clk, rst_n, scl_m, sda_m, sda_oe, oe_prev;
  wire  sda_bus = sda_m & ~sda_oe;
  int   checks, errors, viol, cyc;
  logic [7:0] model [512];

  twi_mem_slave dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && (sda_oe != oe_prev) && scl_m) viol++;
    oe_prev <= sda_oe;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<190000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q / 2);
    acked = (sda_bus == 1'b0);
    tick(Q - Q / 2); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl_m = 1'b1; tick(Q / 2);
      b = {b[6:0], sda_bus};
      tick(Q - Q / 2); scl_m = 1'b0;
    end
    tick(Q);
    sda_m = give_ack ? 1'b0 : 1'b1;
    tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic write_one(input logic [3:0] t, input logic [8:0] a,
                           input logic [7:0] d, output logic ok);
    logic k0, k1, k2;
    bus_start();
    send_byte({t, 2'b00, a[8], 1'b0}, k0);
    send_byte(a[7:0], k1);
    send_byte(d, k2);
    bus_stop();
    ok = k0 & k1 & k2;
    if (t == T_ARR) model[a] = d;
  endtask

  task automatic set_addr(input logic [3:0] t, input logic [8:0] a);
    logic k;
    bus_start();
    send_byte({t, 2'b00, a[8], 1'b0}, k);
    send_byte(a[7:0], k);
    bus_stop();
  endtask

  task automatic rand_read(input logic [3:0] t, input logic [8:0] a, output logic [7:0] d);
    logic k;
    bus_start();
    send_byte({t, 2'b00, a[8], 1'b0}, k);
    send_byte(a[7:0], k);
    bus_start();
    send_byte({t, 2'b00, a[8], 1'b1}, k);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic cur_read(input logic [3:0] t, input logic a8, output logic [7:0] d);
    logic k;
    bus_start();
    send_byte({t, 2'b00, a8, 1'b1}, k);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    logic       ok, k;
    logic [7:0] d;
    checks = 0; errors = 0; viol = 0; cyc = 0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; oe_prev = 1'b0;
    tick(5);
    check({15'd0, sda_oe}, 16'd0, "R12 line released in reset");
    rst_n = 1'b1;
    tick(5);
    rand_read(T_REG, 9'h1FF, d); check({8'd0, d}, 16'h0000, "R12 control reg after reset");
    rand_read(T_REG, 9'h0FF, d); check({8'd0, d}, 16'h0000, "R12 fault reg after reset");

    // vector table: byte writes, then random reads back
    for (int i = 0; i < NVEC; i++) begin
      write_one(T_ARR, VEC[i][16:8], VEC[i][7:0], ok);
      check({15'd0, ok}, 16'd1, "R3 acks on byte write");
    end
    for (int i = 0; i < NVEC; i++) begin
      rand_read(T_ARR, VEC[i][16:8], d);
      check({8'd0, d}, {8'd0, VEC[i][7:0]}, "R6 random read of table entry");
    end

    // R2: unknown type and nonzero fixed bits get no acknowledge
    bus_start(); send_byte(8'h90, k); bus_stop();
    check({15'd0, k}, 16'd0, "R2 unknown device type");
    bus_start(); send_byte(8'hA4, k); bus_stop();
    check({15'd0, k}, 16'd0, "R2 nonzero fixed bits");
    bus_start(); send_byte(8'h90, k); send_byte(8'hA0, k); bus_stop();
    check({15'd0, k}, 16'd0, "R2 bus ignored after mismatch until start");
    bus_start(); send_byte(8'hA0, k); bus_stop();
    check({15'd0, k}, 16'd1, "R2 array type acknowledged");

    // R5: set current address
    set_addr(T_ARR, 9'h155);
    cur_read(T_ARR, 1'b0, d);
    check({8'd0, d}, {8'd0, model[9'h155]}, "R5 set-address then current read");

    // R7: counter advance and ignored A8 on read
    set_addr(T_ARR, 9'h0FF);
    cur_read(T_ARR, 1'b0, d); check({8'd0, d}, {8'd0, model[9'h0FF]}, "R7 current read at loaded");
    cur_read(T_ARR, 1'b0, d); check({8'd0, d}, {8'd0, model[9'h100]}, "R7 current read advanced");
    set_addr(T_ARR, 9'h000);
    cur_read(T_ARR, 1'b1, d); check({8'd0, d}, {8'd0, model[9'h000]}, "R7 read address bit 1 ignored");
    write_one(T_ARR, 9'h041, 8'h41, ok);
    write_one(T_ARR, 9'h040, 8'h4E, ok);
    cur_read(T_ARR, 1'b0, d); check({8'd0, d}, 16'h0041, "R7 current read after write");

    // R8/R9: sequential read across the top, then NACK
    set_addr(T_ARR, 9'h1FE);
    bus_start(); send_byte(8'hA1, k);
    recv_byte(1'b1, d); check({8'd0, d}, {8'd0, model[9'h1FE]}, "R8 seq byte 0");
    recv_byte(1'b1, d); check({8'd0, d}, {8'd0, model[9'h1FF]}, "R8 seq byte 1");
    recv_byte(1'b1, d); check({8'd0, d}, {8'd0, model[9'h000]}, "R8 seq wrap to zero");
    recv_byte(1'b0, d); check({8'd0, d}, {8'd0, model[9'h001]}, "R8 seq byte after wrap");
    check({15'd0, sda_oe}, 16'd0, "R9 line released after NACK");
    bus_stop();
    cur_read(T_ARR, 1'b0, d); check({8'd0, d}, {8'd0, model[9'h002]}, "R9 counter kept after NACK");

    // R4: multi-byte write
    bus_start(); send_byte(8'hA0, k); send_byte(8'h10, k);
    send_byte(8'h11, ok); send_byte(8'h22, k); ok = ok & k; send_byte(8'h33, k); ok = ok & k;
    bus_stop();
    model[9'h010] = 8'h11; model[9'h011] = 8'h22; model[9'h012] = 8'h33;
    check({15'd0, ok}, 16'd1, "R4 acks on data bytes");
    for (int i = 0; i < 3; i++) begin
      rand_read(T_ARR, 9'h010 + 9'(i), d);
      check({8'd0, d}, {8'd0, model[9'h010 + 9'(i)]}, "R4 burst byte stored");
    end

    // R10: register space
    write_one(T_REG, 9'h1FF, 8'h5B, ok); check({15'd0, ok}, 16'd1, "R10 control write acked");
    write_one(T_REG, 9'h0FF, 8'h6C, ok);
    write_one(T_REG, 9'h123, 8'h99, ok);
    rand_read(T_REG, 9'h1FF, d); check({8'd0, d}, 16'h005B, "R10 control reg readback");
    rand_read(T_REG, 9'h0FF, d); check({8'd0, d}, 16'h006C, "R10 fault reg readback");
    rand_read(T_REG, 9'h123, d); check({8'd0, d}, 16'h0000, "R10 unmapped reads zero");
    rand_read(T_ARR, 9'h1FF, d); check({8'd0, d}, {8'd0, model[9'h1FF]}, "R10 array 1FF untouched");
    rand_read(T_ARR, 9'h0FF, d); check({8'd0, d}, {8'd0, model[9'h0FF]}, "R10 array 0FF untouched");

    // R1: start in the middle of a data byte
    write_one(T_ARR, 9'h030, 8'h0F, ok);
    bus_start(); send_byte(8'hA0, k); send_byte(8'h30, k);
    for (int i = 0; i < 3; i++) begin
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
    end
    bus_start(); send_byte(8'hA0, k);
    check({15'd0, k}, 16'd1, "R1 address acked after mid-byte start");
    send_byte(8'h31, ok); send_byte(8'h5E, ok); bus_stop();
    model[9'h031] = 8'h5E;
    rand_read(T_ARR, 9'h031, d); check({8'd0, d}, 16'h005E, "R1 write after restart");
    rand_read(T_ARR, 9'h030, d); check({8'd0, d}, 16'h000F, "R1 partial byte discarded");

    check(16'(viol), 16'd0, "R11 drive changes only with clock low");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule